// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Space Tags

This block holds a small set of cached page-table entries. Each entry maps a virtual page number to a physical frame number and carries an address-space tag and access rights. Any entry can hold any page. A lookup compares the presented page number and the current address-space tag against every entry in the same cycle. The result is one of three outcomes: a hit that returns the physical address, a protection fault, or a miss. Pages and frames are the same size, so the low offset bits pass from the virtual address to the physical address unchanged.

After a miss, an external handler installs the missing mapping through the refill port. The entry goes to a free slot when one exists. When every slot is full, the entry replaces a slot picked by a free-running pseudo-random generator. Two flush commands are provided: one clears every mapping, and the other clears only the mappings of one address space.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: A lookup hits only when an entry is valid and both its page number and its address-space tag equal the request. The hit is reported in the same cycle, with `lk_paddr` = {frame, offset of the request}.
- R3: A read to a matching entry whose read right is 0 raises `lk_fault`. A write to a matching entry whose write right is 0 also raises `lk_fault`. On a fault `lk_hit` is 0 and `lk_paddr` is zero.
- R4: While `lk_valid` is 1, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is 1. While `lk_valid` is 0, all three are 0. `lk_paddr` is zero whenever `lk_hit` is 0.
- R5: A refill becomes visible to lookups from the cycle after `fill_en` is sampled, and not in the same cycle.
- R6: A refill whose page number and tag already match an entry overwrites that entry with the new frame and rights. No mapping is ever held twice.
- R7: While any slot is free, a refill takes a free slot. Eight distinct refills into an empty eight-entry buffer leave all eight mappings resident.
- R8: When the buffer is full, a new refill evicts exactly one resident mapping, chosen by the pseudo-random generator. All the other mappings stay.
- R9: `flush_all` clears every entry from the next cycle.
- R10: `flush_asid_en` clears every entry whose tag equals `flush_asid` and leaves entries with other tags resident.
- R11: A flush takes priority over a refill in the same cycle, and that refill is dropped.
- R12: The same page number under two different tags is held as two independent mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address: page number in [31:12], offset in [11:0] |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| cur_asid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids this access |
| lk_paddr | output | 32 | Physical address on a hit, zero otherwise |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | Tag to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_rd | input | 1 | Read right of the new mapping |
| fill_wr | input | 1 | Write right of the new mapping |
| flush_all | input | 1 | Clear all entries |
| flush_asid_en | input | 1 | Clear the entries of one tag |
| flush_asid | input | 8 | Tag selected for clearing |

## Verification
Some properties are checked on every cycle: the one-outcome rule, the quiet idle outputs, the zero address on a fault, the absence of duplicate matches, the emptiness after a full flush, the absence of the flushed tag after a selective flush, the rule that a refill never shrinks the set, and the fact that the random generator never locks up at zero. Other behaviour needs a reference model of the mapping set, so only the bench scenarios can show it. That includes correct frames and rights on hits, the one-cycle refill latency, overwriting, tag separation, the drop of a refill that meets a flush, and the rule that a refill into a full buffer loses exactly one mapping. For that last case the bench probes every old mapping afterwards.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int TLB_VPN_W  = 20;
    parameter int TLB_PFN_W  = 20;
    parameter int TLB_OFF_W  = 12;
    parameter int TLB_ASID_W = 8;

    typedef struct packed {
        logic                  v;
        logic                  rd;
        logic                  wr;
        logic [TLB_ASID_W-1:0] asid;
        logic [TLB_VPN_W-1:0]  vpn;
        logic [TLB_PFN_W-1:0]  pfn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);                                             // R8
    AST_LFSR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lfsr_q != $past(lfsr_q));                 // R8
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0]  ent,
    input  logic [TLB_VPN_W-1:0]      vpn,
    input  logic [TLB_ASID_W-1:0]     asid,
    output logic [ENTRIES-1:0]        match,
    output logic                      any,
    output logic [IDX_W-1:0]          idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent[g].v && (ent[g].vpn == vpn) && (ent[g].asid == asid);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic               same_any,
    input  logic [IDX_W-1:0]   same_idx,
    input  logic [IDX_W-1:0]   rnd,
    output logic [IDX_W-1:0]   slot
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // existing mapping first, then a free slot, then a random one
    always_comb begin
        if (same_any)      slot = same_idx;
        else if (free_any) slot = free_idx;
        else               slot = rnd;
    end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LFSR_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lk_valid,
    input  logic [TLB_VPN_W+TLB_OFF_W-1:0] lk_vaddr,
    input  logic                           lk_write,
    input  logic [TLB_ASID_W-1:0]          cur_asid,
    output logic                           lk_hit,
    output logic                           lk_miss,
    output logic                           lk_fault,
    output logic [TLB_PFN_W+TLB_OFF_W-1:0] lk_paddr,
    input  logic                           fill_en,
    input  logic [TLB_VPN_W-1:0]           fill_vpn,
    input  logic [TLB_ASID_W-1:0]          fill_asid,
    input  logic [TLB_PFN_W-1:0]           fill_pfn,
    input  logic                           fill_rd,
    input  logic                           fill_wr,
    input  logic                           flush_all,
    input  logic                           flush_asid_en,
    input  logic [TLB_ASID_W-1:0]          flush_asid
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] valid_vec;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = st_q.ent[g].v;
    end

    // lookup path
    logic [ENTRIES-1:0] lk_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;

    tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_cam (
        .ent   (st_q.ent),
        .vpn   (lk_vaddr[TLB_VPN_W+TLB_OFF_W-1:TLB_OFF_W]),
        .asid  (cur_asid),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    tlb_entry_t sel;
    logic       perm_ok;
    assign sel     = st_q.ent[lk_idx];
    assign perm_ok = lk_write ? sel.wr : sel.rd;

    always_comb begin
        lk_hit   = lk_valid && lk_any && perm_ok;
        lk_fault = lk_valid && lk_any && !perm_ok;
        lk_miss  = lk_valid && !lk_any;
        lk_paddr = lk_hit ? {sel.pfn, lk_vaddr[TLB_OFF_W-1:0]} : '0;
    end

    // refill slot choice
    logic [ENTRIES-1:0] fill_match;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_idx;
    logic [LFSR_W-1:0]  rnd;
    logic [IDX_W-1:0]   fill_slot;

    tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_fill_cam (
        .ent   (st_q.ent),
        .vpn   (fill_vpn),
        .asid  (fill_asid),
        .match (fill_match),
        .any   (fill_any),
        .idx   (fill_idx)
    );

    tlb_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid    (valid_vec),
        .same_any (fill_any),
        .same_idx (fill_idx),
        .rnd      (rnd[IDX_W-1:0]),
        .slot     (fill_slot)
    );

    // next state: flush beats refill
    always_comb begin
        st_d = st_q;
        if (flush_all) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].v = 1'b0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.ent[i].asid == flush_asid) st_d.ent[i].v = 1'b0;
            end
        end else if (fill_en) begin
            st_d.ent[fill_slot].v    = 1'b1;
            st_d.ent[fill_slot].rd   = fill_rd;
            st_d.ent[fill_slot].wr   = fill_wr;
            st_d.ent[fill_slot].asid = fill_asid;
            st_d.ent[fill_slot].vpn  = fill_vpn;
            st_d.ent[fill_slot].pfn  = fill_pfn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // checks
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);          // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> ({lk_hit, lk_miss, lk_fault} == 3'b000 && lk_paddr == '0)); // R4
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_paddr == '0 && !lk_hit));                          // R3
    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fill_match));                        // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> valid_vec == '0);                                     // R9
    AST_FILL_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en) |=>
            $countones(valid_vec) >= $past($countones(valid_vec)));         // R7

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ast
        AST_ASID_GONE: assert property (@(posedge clk) disable iff (!rst_n)
            flush_asid_en |=> !(st_q.ent[g].v && st_q.ent[g].asid == $past(flush_asid))); // R10
    end
endmodule

// File: tb/tlb_assoc_tb_top.sv
`timescale 1ns/1ps
module tlb_assoc_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_rd = 1'b0;
    logic        fill_wr = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_asid_en = 1'b0;
    logic [7:0]  flush_asid = '0;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    tlb_assoc #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .cur_asid(cur_asid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
        .fill_rd(fill_rd), .fill_wr(fill_wr),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    // reference model: a set of mappings, slot positions not tracked
    bit          mv[N];
    logic [19:0] mvpn[N];
    logic [7:0]  masid[N];
    logic [19:0] mpfn[N];
    bit          mrd[N];
    bit          mwr[N];

    function automatic int mfind(logic [19:0] vpn, logic [7:0] asid);
        for (int i = 0; i < N; i++)
            if (mv[i] && mvpn[i] == vpn && masid[i] == asid) return i;
        return -1;
    endfunction

    function automatic int mfree();
        for (int i = 0; i < N; i++) if (!mv[i]) return i;
        return -1;
    endfunction

    // expected {hit,miss,fault,paddr}
    function automatic logic [34:0] mexpect(logic [19:0] vpn, logic [7:0] asid,
                                            bit wr, logic [11:0] off);
        int  i;
        bit  ok;
        i = mfind(vpn, asid);
        if (i < 0) return {3'b010, 32'h0};
        ok = wr ? mwr[i] : mrd[i];
        if (ok) return {3'b100, mpfn[i], off};
        return {3'b001, 32'h0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic raw_lookup(input logic [19:0] vpn, input logic [7:0] asid, input bit wr,
                              input logic [11:0] off, output logic [34:0] res);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr; cur_asid = asid;
        #1;
        res = {lk_hit, lk_miss, lk_fault, lk_paddr};
    endtask

    task automatic check_lookup(input logic [19:0] vpn, input logic [7:0] asid, input bit wr,
                                input logic [11:0] off, input string req);
        logic [34:0] res, exp;
        exp = mexpect(vpn, asid, wr, off);
        raw_lookup(vpn, asid, wr, off, res);
        chk(res === exp, req, 64'(res), 64'(exp));
    endtask

    task automatic probe_after_full(input logic [19:0] vpn, input logic [7:0] asid,
                                    input logic [19:0] pfn, input bit rd, input bit wr);
        logic [34:0] res;
        int gone = -1;
        int cnt = 0;
        for (int k = 0; k < N; k++) begin
            raw_lookup(mvpn[k], masid[k], 1'b0, 12'h0, res);
            if (res[33]) begin cnt++; gone = k; end
        end
        chk(cnt == 1, "R8 evicted count", 64'(cnt), 64'd1);
        if (gone < 0) gone = 0;
        mvpn[gone] = vpn; masid[gone] = asid; mpfn[gone] = pfn;
        mrd[gone] = rd; mwr[gone] = wr; mv[gone] = 1'b1;
        check_lookup(vpn, asid, 1'b0, 12'h0, "R8 new mapping");
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [7:0] asid,
                           input logic [19:0] pfn, input bit rd, input bit wr);
        int i;
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_rd = rd; fill_wr = wr;
        @(negedge clk);
        fill_en = 1'b0;
        i = mfind(vpn, asid);
        if (i < 0) i = mfree();
        if (i >= 0) begin
            mvpn[i] = vpn; masid[i] = asid; mpfn[i] = pfn;
            mrd[i] = rd; mwr[i] = wr; mv[i] = 1'b1;
        end else begin
            probe_after_full(vpn, asid, pfn, rd, wr);
        end
    endtask

    task automatic do_flush(input bit all, input logic [7:0] asid);
        @(negedge clk);
        flush_all = all; flush_asid_en = !all; flush_asid = asid;
        @(negedge clk);
        flush_all = 1'b0; flush_asid_en = 1'b0;
        for (int i = 0; i < N; i++)
            if (all || masid[i] == asid) mv[i] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [34:0] res;
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        check_lookup(20'h5, 8'h1, 1'b0, 12'h0, "R1 reset miss");
        // R4: idle outputs quiet
        @(negedge clk); lk_valid = 1'b0; #1;
        chk({lk_hit, lk_miss, lk_fault, lk_paddr} == 35'h0, "R4 idle",
            64'({lk_hit, lk_miss, lk_fault, lk_paddr}), 64'h0);

        // R5: not visible in the fill cycle, visible after
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h5; fill_asid = 8'h1; fill_pfn = 20'h123;
        fill_rd = 1'b1; fill_wr = 1'b1;
        lk_valid = 1'b1; lk_vaddr = {20'h5, 12'hABC}; lk_write = 1'b0; cur_asid = 8'h1;
        #1;
        chk(lk_miss === 1'b1, "R5 same-cycle miss", 64'(lk_miss), 64'd1);
        @(negedge clk);
        fill_en = 1'b0;
        mv[0] = 1'b1; mvpn[0] = 20'h5; masid[0] = 8'h1; mpfn[0] = 20'h123; mrd[0] = 1; mwr[0] = 1;
        #1;
        chk({lk_hit, lk_paddr} === {1'b1, 32'h00123ABC}, "R5 R2 next-cycle hit",
            64'({lk_hit, lk_paddr}), 64'({1'b1, 32'h00123ABC}));
        check_lookup(20'h5, 8'h1, 1'b1, 12'h010, "R2 write hit");

        // R12: same page, other tag
        check_lookup(20'h5, 8'h2, 1'b0, 12'h0, "R12 other tag misses");
        do_fill(20'h5, 8'h2, 20'h456, 1'b1, 1'b0);
        check_lookup(20'h5, 8'h2, 1'b0, 12'h7, "R12 second mapping");
        check_lookup(20'h5, 8'h1, 1'b0, 12'h7, "R12 first mapping kept");
        // R3: write to read-only, read to no-read page
        check_lookup(20'h5, 8'h2, 1'b1, 12'h7, "R3 write fault");
        do_fill(20'h9, 8'h1, 20'h99, 1'b0, 1'b1);
        check_lookup(20'h9, 8'h1, 1'b0, 12'h1, "R3 read fault");
        check_lookup(20'h9, 8'h1, 1'b1, 12'h1, "R3 write allowed");

        // R6: overwrite
        do_fill(20'h5, 8'h1, 20'h777, 1'b1, 1'b0);
        check_lookup(20'h5, 8'h1, 1'b0, 12'h3, "R6 new frame");
        check_lookup(20'h5, 8'h1, 1'b1, 12'h3, "R6 new rights");

        // R10: tag-selective flush
        do_flush(1'b0, 8'h2);
        check_lookup(20'h5, 8'h2, 1'b0, 12'h0, "R10 flushed tag");
        check_lookup(20'h5, 8'h1, 1'b0, 12'h0, "R10 other tag kept");

        // R9 R11: full flush wins over a refill
        @(negedge clk);
        flush_all = 1'b1; fill_en = 1'b1; fill_vpn = 20'h33; fill_asid = 8'h1;
        fill_pfn = 20'h33; fill_rd = 1'b1; fill_wr = 1'b1;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        check_lookup(20'h5, 8'h1, 1'b0, 12'h0, "R9 cleared");
        check_lookup(20'h33, 8'h1, 1'b0, 12'h0, "R11 refill dropped");

        // R7: fill all slots, all resident
        for (int k = 0; k < N; k++) do_fill(20'(16 + k), 8'h3, 20'(256 + k), 1'b1, 1'b1);
        for (int k = 0; k < N; k++)
            check_lookup(20'(16 + k), 8'h3, 1'b0, 12'(k), "R7 resident");
        // R8: one more evicts exactly one
        do_fill(20'h40, 8'h3, 20'h400, 1'b1, 1'b1);
        do_fill(20'h41, 8'h3, 20'h401, 1'b1, 1'b0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [19:0] v;
            logic [7:0]  a;
            op = $urandom_range(0, 99);
            v  = 20'($urandom_range(0, 11));
            a  = 8'($urandom_range(0, 2));
            if (op < 55)
                check_lookup(v, a, 1'($urandom_range(0, 1)), 12'($urandom), "R2 R3 random lookup");
            else if (op < 90)
                do_fill(v, a, 20'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
            else if (op < 97)
                do_flush(1'b0, a);
            else
                do_flush(1'b1, 8'h0);
        end

        @(negedge clk); lk_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule